// File: doc/BRIEF.md
# Guarded SPI Slave Transceiver

This block is an 8-bit serial slave. It shifts a byte out on MISO while it shifts a byte in from MOSI. The transfer is paced by an external SCK and framed by an active-low select. The serial inputs are passed through two-flop synchronisers into a faster system clock. All internal state is updated on detected SCK edges in that clock domain.

Software picks one of four clock modes with a polarity bit and a phase bit. It loads the byte to send through a host write port and receives each incoming byte with a one-cycle completion pulse. The transmit holding register is locked while the slave is selected. A host write made during that time is dropped and raises a sticky collision flag, which a clear strobe resets.

Top module: `spi_slave_guard`

## Requirements
- R1: After reset, rx_data_o is 0, rx_done_o is 0, coll_o is 0, miso_oe_o is 0, and the transmit holding register is 0.
- R2: Each byte is exchanged in exactly eight SCK cycles, most significant bit first. rx_data_o receives the eight MOSI bits, and MISO carries the holding register's eight bits. This holds in all four modes.
- R3: The capture edge is the first SCK edge of each bit when cfg_cpha_i=0 and the second edge when cfg_cpha_i=1. The first edge is rising when cfg_cpol_i=0 and falling when cfg_cpol_i=1. With cfg_cpha_i=1, the first edge of each bit drives that bit onto MISO.
- R4: On the eighth capture edge, the assembled byte moves into rx_data_o and rx_done_o pulses high for exactly one system clock.
- R5: While select is high, the bit counter is held at zero. A partly shifted byte is discarded, and the next selection starts a fresh byte.
- R6: A host write with select high loads wr_data_i into the holding register. A host write with select low leaves the holding register unchanged.
- R7: A write with select low sets coll_o. coll_o stays set until a coll_clr_i pulse. If a blocked write and a clear arrive in the same cycle, the set wins.
- R8: While select is high, miso_oe_o is 0 and miso_o is 0.
- R9: With cfg_cpha_i=0, the holding register's MSB appears on miso_o after select falls and before the first SCK edge.
- R10: With cfg_cpha_i=1, select may stay low across consecutive bytes. Each byte completes on its own, and each resends the holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cpol_i | input | 1 | Clock polarity; also the SCK idle level |
| cfg_cpha_i | input | 1 | Clock phase: 0 captures on the first edge, 1 on the second |
| sck_i | input | 1 | Serial clock from the master |
| mosi_i | input | 1 | Serial data in |
| sel_n_i | input | 1 | Active-low slave select |
| miso_o | output | 1 | Serial data out, 0 when not selected |
| miso_oe_o | output | 1 | MISO output enable, high only while selected |
| wr_en_i | input | 1 | Host write strobe for the holding register |
| wr_data_i | input | 8 | Host write data |
| coll_clr_i | input | 1 | Clears the collision flag |
| coll_o | output | 1 | Sticky write-collision flag |
| rx_data_o | output | 8 | Last completed received byte |
| rx_done_o | output | 1 | One-cycle pulse when a byte completes |

## Verification
The assertions assume that each SCK level, and MOSI around each capture edge, stays stable for several system clocks, so that every edge is seen once after synchronisation. They also assume that the polarity and phase bits change only while select is high and SCK rests at its idle level. The stimulus holds every SCK half period for eight system clocks and changes MOSI only at launch edges. It reprograms the mode only between selections, after setting SCK to the new idle level. Host writes are issued only after select has settled for many clocks, so each write falls clearly inside or outside a selection.

// File: rtl/spi_guard_pkg.sv
package spi_guard_pkg;
  localparam int DW = 8;
  localparam int CW = $clog2(DW);

  typedef struct packed {
    logic cpol;
    logic cpha;
  } spi_mode_t;

  // edge moving away from the idle level
  function automatic logic lead_edge(input spi_mode_t m, input logic rise, input logic fall);
    return m.cpol ? fall : rise;
  endfunction

  function automatic logic capture_edge(input spi_mode_t m, input logic lead, input logic trail);
    return m.cpha ? trail : lead;
  endfunction

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c);
    return (c == CW'(DW - 1)) ? '0 : c + 1'b1;
  endfunction
endpackage

// File: rtl/spi_guard_sync.sv
module spi_guard_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_guard_txreg.sv
module spi_guard_txreg
  import spi_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_act,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          coll_clr,
  output logic [DW-1:0] tx_word,
  output logic          coll
);
  logic wr_blocked, wr_accept;
  assign wr_blocked = wr_en & sel_act;
  assign wr_accept  = wr_en & ~sel_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_word <= '0;
      coll    <= 1'b0;
    end else begin
      if (wr_accept) tx_word <= wr_data;
      if (wr_blocked) coll <= 1'b1;
      else if (coll_clr) coll <= 1'b0;
    end
  end

  AST_TX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> tx_word == $past(tx_word)); // R6
  AST_TX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> tx_word == $past(wr_data)); // R6
  AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (coll && !coll_clr) |=> coll); // R7
  AST_COLL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> coll); // R7
endmodule

// File: rtl/spi_guard_engine.sv
module spi_guard_engine
  import spi_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  spi_mode_t     mode,
  input  logic          sck_s,
  input  logic          mosi_s,
  input  logic          sel_act,
  input  logic [DW-1:0] tx_word,
  output logic          tx_bit,
  output logic [DW-1:0] rx_word,
  output logic          rx_done
);
  logic          sck_q, sel_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rx_sh, tx_sh;

  // named internal events
  logic sck_rise, sck_fall, lead, trail, cap_ev, launch_ev, sel_fall, last_bit;
  assign sck_rise  = sck_s & ~sck_q;
  assign sck_fall  = ~sck_s & sck_q;
  assign lead      = lead_edge(mode, sck_rise, sck_fall);
  assign trail     = lead_edge(mode, sck_fall, sck_rise);
  assign cap_ev    = sel_act & capture_edge(mode, lead, trail);
  assign launch_ev = sel_act & capture_edge(mode, trail, lead);
  assign sel_fall  = sel_act & ~sel_q;
  assign last_bit  = (cnt == CW'(DW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q   <= 1'b0;
      sel_q   <= 1'b0;
      cnt     <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      rx_word <= '0;
      rx_done <= 1'b0;
    end else begin
      sck_q   <= sck_s;
      sel_q   <= sel_act;
      rx_done <= 1'b0;
      if (!sel_act) begin
        cnt <= '0;
      end else if (cap_ev) begin
        cnt   <= next_count(cnt);
        rx_sh <= {rx_sh[DW-2:0], mosi_s};
        if (last_bit) begin
          rx_word <= {rx_sh[DW-2:0], mosi_s};
          rx_done <= 1'b1;
        end
      end
      if (sel_fall) tx_sh <= tx_word;
      else if (launch_ev) begin
        if (mode.cpha && cnt == '0) tx_sh <= tx_word;
        else tx_sh <= {tx_sh[DW-2:0], 1'b0};
      end
    end
  end

  assign tx_bit = tx_sh[DW-1];

  AST_DONE_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |-> $past(cap_ev)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> !rx_done); // R4
  AST_FRESH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fall |-> cnt == '0); // R5
  AST_MSB_ON_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_fall && !mode.cpha) |=> tx_bit == $past(tx_word[DW-1])); // R9
endmodule

// File: rtl/spi_slave_guard.sv
module spi_slave_guard
  import spi_guard_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_cpol_i,
  input  logic          cfg_cpha_i,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          sel_n_i,
  output logic          miso_o,
  output logic          miso_oe_o,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          coll_clr_i,
  output logic          coll_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_done_o
);
  logic [2:0]    sync_q;
  logic          sel_act, tx_bit;
  logic [DW-1:0] tx_word;
  spi_mode_t     mode;

  assign mode = '{cpol: cfg_cpol_i, cpha: cfg_cpha_i};

  spi_guard_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_i({sel_n_i, mosi_i, sck_i}), .q_o(sync_q));

  assign sel_act = ~sync_q[2];

  spi_guard_txreg u_txreg (
    .clk(clk), .rst_n(rst_n), .sel_act(sel_act), .wr_en(wr_en_i),
    .wr_data(wr_data_i), .coll_clr(coll_clr_i), .tx_word(tx_word), .coll(coll_o));

  spi_guard_engine u_engine (
    .clk(clk), .rst_n(rst_n), .mode(mode), .sck_s(sync_q[0]), .mosi_s(sync_q[1]),
    .sel_act(sel_act), .tx_word(tx_word), .tx_bit(tx_bit),
    .rx_word(rx_data_o), .rx_done(rx_done_o));

  assign miso_oe_o = sel_act;
  assign miso_o    = sel_act & tx_bit;

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sel_n_i, 2) && $past(sel_n_i) |-> !miso_oe_o && !miso_o); // R8
endmodule

// File: tb/spi_slave_guard_test.sv
module spi_slave_guard_test;
  localparam int H = 8;
  logic clk = 0, rst_n = 0;
  logic cpol = 0, cpha = 0, sck = 0, mosi = 0, sel_n = 1;
  logic wr_en = 0, coll_clr = 0;
  logic [7:0] wr_data = 0;
  logic miso, miso_oe, coll, rx_done;
  logic [7:0] rx_data;
  int total = 0, bad = 0, done_cnt = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_slave_guard uut (
    .clk(clk), .rst_n(rst_n), .cfg_cpol_i(cpol), .cfg_cpha_i(cpha),
    .sck_i(sck), .mosi_i(mosi), .sel_n_i(sel_n), .miso_o(miso), .miso_oe_o(miso_oe),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .coll_clr_i(coll_clr), .coll_o(coll),
    .rx_data_o(rx_data), .rx_done_o(rx_done));

  always @(posedge clk) if (rst_n && rx_done) done_cnt <= done_cnt + 1;

  // {cpol, cpha, tx byte, mosi byte}
  localparam logic [17:0] VEC [8] = '{
    {2'b00, 8'hA5, 8'h3C}, {2'b01, 8'h81, 8'h7E}, {2'b10, 8'h5A, 8'hC3},
    {2'b11, 8'hFF, 8'h01}, {2'b00, 8'h01, 8'h80}, {2'b01, 8'h6D, 8'hB2},
    {2'b10, 8'h00, 8'hFF}, {2'b11, 8'h96, 8'h69}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic p, input logic h);
    cpol = p; cpha = h; sck = p; tick(H);
  endtask

  task automatic host_write(input logic [7:0] d);
    wr_data = d; wr_en = 1; tick(1); wr_en = 0; tick(1);
  endtask

  // clocks nbits bits with select already low; returns bits seen on MISO
  task automatic shift_bits(input logic [7:0] mo, input int nbits, output logic [7:0] mi);
    mi = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      if (!cpha) begin
        mosi = mo[i]; tick(H);
        mi[i] = miso; sck = ~sck; tick(H);
        sck = ~sck;
      end else begin
        sck = ~sck; mosi = mo[i]; tick(H);
        mi[i] = miso; sck = ~sck; tick(H);
      end
    end
    tick(H);
  endtask

  initial begin : main
    logic [7:0] got;
    int d0;
    tick(3); rst_n = 1; tick(2);
    chk("R1 rx_data", rx_data, 0);
    chk("R1 rx_done", rx_done, 0);
    chk("R1 coll", coll, 0);
    chk("R1 miso_oe", miso_oe, 0);
    set_mode(0, 0); sel_n = 0; tick(H);
    chk("R1 holding reg zero", miso, 0);
    sel_n = 1; tick(H);

    for (int v = 0; v < 8; v++) begin
      set_mode(VEC[v][17], VEC[v][16]);
      host_write(VEC[v][15:8]);
      d0 = done_cnt;
      sel_n = 0; tick(H);
      if (!cpha) chk("R9 msb before first edge", miso, VEC[v][15]);
      shift_bits(VEC[v][7:0], 8, got);
      chk("R2 R3 miso byte", got, VEC[v][15:8]);
      chk("R2 R3 rx byte", rx_data, VEC[v][7:0]);
      chk("R4 one done", done_cnt - d0, 1);
      sel_n = 1; tick(H);
      chk("R8 oe off", miso_oe, 0);
      chk("R8 miso low", miso, 0);
    end

    // R6 / R7 collision
    set_mode(0, 1); host_write(8'hC6);
    sel_n = 0; tick(H);
    host_write(8'h11);
    chk("R7 coll set", coll, 1);
    tick(20);
    chk("R7 coll sticky", coll, 1);
    shift_bits(8'h00, 8, got);
    chk("R6 blocked write ignored", got, 8'hC6);
    sel_n = 1; tick(H);
    coll_clr = 1; wr_en = 1; wr_data = 8'h22; tick(1);
    chk("R6 write accepted no coll", coll, 0);
    coll_clr = 0; wr_en = 0;
    sel_n = 0; tick(H);
    wr_en = 1; coll_clr = 1; tick(1); wr_en = 0; coll_clr = 0; tick(1);
    chk("R7 set beats clear", coll, 1);
    sel_n = 1; tick(H);
    coll_clr = 1; tick(1); coll_clr = 0; tick(1);
    chk("R7 cleared", coll, 0);

    // R5 aborted partial byte
    set_mode(1, 0); host_write(8'hB4);
    d0 = done_cnt;
    sel_n = 0; tick(H);
    shift_bits(8'hFF, 3, got);
    sel_n = 1; sck = cpol; tick(H);
    sel_n = 0; tick(H);
    shift_bits(8'h4B, 8, got);
    chk("R5 fresh rx", rx_data, 8'h4B);
    chk("R5 fresh tx", got, 8'hB4);
    chk("R5 done count", done_cnt - d0, 1);
    sel_n = 1; tick(H);

    // R10 back-to-back with select held low
    set_mode(1, 1); host_write(8'hE7);
    d0 = done_cnt;
    sel_n = 0; tick(H);
    shift_bits(8'h12, 8, got);
    chk("R10 byte1 rx", rx_data, 8'h12);
    chk("R10 byte1 tx", got, 8'hE7);
    shift_bits(8'hED, 8, got);
    chk("R10 byte2 rx", rx_data, 8'hED);
    chk("R10 byte2 tx", got, 8'hE7);
    chk("R10 two dones", done_cnt - d0, 2);
    sel_n = 1; tick(H);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule